// File: doc/BRIEF.md
# Branch target address resolver

This block resolves the destination of an unconditional branch and hands it to the program counter. The decoder gives it an addressing mode, the program counter of the branch, a source register value and an extension word, which holds the immediate value, the absolute address or the index. From these the block either takes the destination directly, or forms a pointer and reads the 20-bit destination from memory as two 16-bit words, the low word first and then the high word.

The memory port is a read-only valid/ready handshake with data returned in the cycle that ready is high. When the sequence completes, the block raises a one-cycle completion pulse together with the program-counter write enable. In post-increment mode it also raises a write-back of the pointer register, advanced by four, in the same cycle. It never touches any status flag or mode bit. While a branch is in progress, further requests are dropped.

Top module: `branch_target_resolver`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `pc_we`, `reg_we` and `mem_rd_valid` are all 0.
- R2: Mode 0 (immediate): the destination is `req_ext`. No memory read is made, and `done` is high in the cycle after the request is accepted.
- R3: Mode 1 (register): the destination is `req_reg`. No memory read is made, and `done` is high in the cycle after acceptance.
- R4: In the memory modes (2 to 6) exactly two reads are made, first at pointer P and then at P+2 (modulo 2^20). The destination is {high word bits [3:0], low word}.
- R5: Mode 2 (PC-relative) uses P = `req_pc` + offset, and mode 6 (indexed) uses P = `req_reg` + offset. When `req_wide` is 0, the offset is `req_ext[15:0]` sign-extended to 20 bits. All sums wrap modulo 2^20.
- R6: When `req_wide` is 1, the offset in modes 2 and 6 is the full 20-bit `req_ext`.
- R7: Mode 3 (absolute) uses P = `req_ext`, and mode 4 (register-indirect) uses P = `req_reg`.
- R8: Mode 5 (post-increment) reads like mode 4. In the cycle where `pc_we` is high, it also raises `reg_we` with `reg_wdata` = `req_reg`+4 modulo 2^20. In every other mode `reg_we` stays 0.
- R9: While `mem_rd_valid` is high and `mem_rd_ready` is low, the block waits and keeps `mem_rd_addr` unchanged. A memory mode completes 3+2·S cycles after acceptance, where S is the number of wait cycles on each read.
- R10: `done` and `pc_we` are high together for exactly one cycle per branch, and `pc_next` then carries the destination.
- R11: A request is accepted only while `busy` is 0. A request made while busy has no effect on the destination and starts no further branch.
- R12: Mode code 7 is ignored: no read, no `done`, and `busy` stays 0.
- R13: The upper 12 bits of the high word do not affect the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request strobe |
| req_mode | input | 3 | Addressing mode code (0 to 6, 7 ignored) |
| req_wide | input | 1 | Use full 20-bit index instead of sign-extended 16-bit |
| req_pc | input | 20 | Program counter used as base in PC-relative mode |
| req_reg | input | 20 | Source register value |
| req_ext | input | 20 | Immediate, absolute address or index |
| busy | output | 1 | Branch in progress |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 20 | Memory read address |
| mem_rd_ready | input | 1 | Memory read accepted, data valid |
| mem_rd_data | input | 16 | Memory read data |
| pc_we | output | 1 | Program counter write enable |
| pc_next | output | 20 | New program counter value |
| reg_we | output | 1 | Pointer register write-back enable |
| reg_wdata | output | 20 | Pointer register write-back value |
| done | output | 1 | One-cycle completion pulse |

## Verification
In post-increment mode, the program-counter load and the pointer-register write-back must fall in the same completing cycle. The bench runs that mode with a pointer near the top of the address space, so the second read address and the write-back value both wrap, and it also adds memory wait cycles. At the cycle where `done` is first seen, it checks `pc_we`, `reg_we`, `pc_next` and `reg_wdata` together against values computed in the bench. One cycle later it checks that both enables have dropped.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ADDR_W   = 20;
  localparam int WORD_W   = 16;
  localparam int IDX_W    = 16;
  localparam int HI_BITS  = ADDR_W - WORD_W;
  localparam int WORD_STEP = 2;
  localparam int PTR_STEP  = 2 * WORD_STEP;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    MD_IMM = 3'd0,
    MD_REG = 3'd1,
    MD_SYM = 3'd2,
    MD_ABS = 3'd3,
    MD_IND = 3'd4,
    MD_INC = 3'd5,
    MD_IDX = 3'd6
  } mode_e;

  function automatic addr_t wrap_add(input addr_t a, input addr_t b);
    return a + b;
  endfunction

  function automatic addr_t form_offset(input addr_t ext, input logic wide);
    if (wide) return ext;
    return {{(ADDR_W-IDX_W){ext[IDX_W-1]}}, ext[IDX_W-1:0]};
  endfunction

  function automatic logic mode_legal(input logic [2:0] m);
    return m <= 3'd6;
  endfunction

  function automatic logic mode_fetches(input logic [2:0] m);
    return mode_legal(m) && (m != 3'd0) && (m != 3'd1);
  endfunction
endpackage

// File: rtl/brt_addr_gen.sv
module brt_addr_gen
  import brt_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       wide,
  input  addr_t      pc,
  input  addr_t      rval,
  input  addr_t      ext,
  output addr_t      ptr,
  output addr_t      direct_tgt
);
  addr_t offset;

  always_comb begin
    offset = form_offset(ext, wide);
    unique case (mode)
      MD_SYM:  ptr = wrap_add(pc, offset);
      MD_IDX:  ptr = wrap_add(rval, offset);
      MD_ABS:  ptr = ext;
      default: ptr = rval;
    endcase
    direct_tgt = (mode == MD_IMM) ? ext : rval;
  end
endmodule

// File: rtl/brt_seq.sv
module brt_seq
  import brt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       mem_rd_ready,
  output logic       accept,
  output logic       accept_direct,
  output logic       busy,
  output logic       mem_rd_valid,
  output logic       fetch_hi,
  output logic       lo_take,
  output logic       hi_take,
  output logic       done,
  output logic       wb_fire
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_DONE} st_e;
  st_e  state;
  logic inc_q;

  assign busy          = (state != ST_IDLE);
  assign accept        = !busy && req_valid && mode_legal(req_mode);
  assign accept_direct = accept && !mode_fetches(req_mode);
  assign mem_rd_valid  = (state == ST_LO) || (state == ST_HI);
  assign fetch_hi      = (state == ST_HI);
  assign lo_take       = (state == ST_LO) && mem_rd_ready;
  assign hi_take       = (state == ST_HI) && mem_rd_ready;
  assign done          = (state == ST_DONE);
  assign wb_fire       = done && inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      inc_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= mode_fetches(req_mode) ? ST_LO : ST_DONE;
          inc_q <= (req_mode == MD_INC);
        end
        ST_LO:   if (mem_rd_ready) state <= ST_HI;
        ST_HI:   if (mem_rd_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3 / R2: direct modes complete next cycle without reading memory
  a_r3_direct_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    accept_direct |=> done && !mem_rd_valid);

  // R12: the unused mode code leaves the block idle
  a_r12_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_mode == 3'd7) |=> !busy);
endmodule

// File: rtl/brt_target.sv
module brt_target
  import brt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  addr_t ptr_in,
  input  addr_t direct_in,
  input  logic  fetch_hi,
  input  logic  lo_take,
  input  logic  hi_take,
  input  word_t rd_data,
  output addr_t rd_addr,
  output addr_t tgt,
  output addr_t wb_val
);
  addr_t ptr_q;
  addr_t tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      tgt_q <= '0;
    end else begin
      if (accept) begin
        ptr_q <= ptr_in;
        tgt_q <= direct_in;
      end
      if (lo_take) tgt_q[WORD_W-1:0] <= rd_data;
      if (hi_take) tgt_q[ADDR_W-1:WORD_W] <= rd_data[HI_BITS-1:0];
    end
  end

  assign rd_addr = fetch_hi ? wrap_add(ptr_q, addr_t'(WORD_STEP)) : ptr_q;
  assign tgt     = tgt_q;
  assign wb_val  = wrap_add(ptr_q, addr_t'(PTR_STEP));

  // R13: a high-word capture changes only the top bits of the target
  a_r13_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    hi_take |=> tgt[WORD_W-1:0] == $past(tgt[WORD_W-1:0]));
endmodule

// File: rtl/branch_target_resolver.sv
module branch_target_resolver
  import brt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_mode,
  input  logic        req_wide,
  input  logic [19:0] req_pc,
  input  logic [19:0] req_reg,
  input  logic [19:0] req_ext,
  output logic        busy,
  output logic        mem_rd_valid,
  output logic [19:0] mem_rd_addr,
  input  logic        mem_rd_ready,
  input  logic [15:0] mem_rd_data,
  output logic        pc_we,
  output logic [19:0] pc_next,
  output logic        reg_we,
  output logic [19:0] reg_wdata,
  output logic        done
);
  addr_t ptr_w, direct_w;
  logic  accept_w, accept_direct_w, fetch_hi_w, lo_take_w, hi_take_w, wb_fire_w;

  brt_addr_gen u_addr (
    .mode(req_mode), .wide(req_wide), .pc(req_pc), .rval(req_reg),
    .ext(req_ext), .ptr(ptr_w), .direct_tgt(direct_w)
  );

  brt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .mem_rd_ready(mem_rd_ready), .accept(accept_w),
    .accept_direct(accept_direct_w), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .fetch_hi(fetch_hi_w), .lo_take(lo_take_w),
    .hi_take(hi_take_w), .done(done), .wb_fire(wb_fire_w)
  );

  brt_target u_tgt (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .ptr_in(ptr_w),
    .direct_in(direct_w), .fetch_hi(fetch_hi_w), .lo_take(lo_take_w),
    .hi_take(hi_take_w), .rd_data(mem_rd_data), .rd_addr(mem_rd_addr),
    .tgt(pc_next), .wb_val(reg_wdata)
  );

  assign pc_we  = done;
  assign reg_we = wb_fire_w;

  // R9: a stalled read keeps its address
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

  // R4: the high-word read follows the low-word read two bytes up
  a_r4_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take_w |=> mem_rd_valid && (mem_rd_addr == $past(mem_rd_addr) + 20'd2));

  // R8: register write-back only alongside the program-counter load
  a_r8_wb_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> pc_we);

  // R1: no activity while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !busy);
endmodule

// File: tb/sim_branch_target_resolver.sv
module sim_branch_target_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic        req_wide = 1'b0;
  logic [19:0] req_pc = '0, req_reg = '0, req_ext = '0;
  logic        busy, mem_rd_valid, mem_rd_ready, pc_we, reg_we, done;
  logic [19:0] mem_rd_addr, pc_next, reg_wdata;
  logic [15:0] mem_rd_data;

  int checks = 0;
  int failures = 0;
  int stall_cfg = 0;
  int stall_cnt = 0;
  int nlog = 0;
  logic [19:0] flog [4];
  bit finished = 0;

  always #5 clk = ~clk;

  branch_target_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_wide(req_wide), .req_pc(req_pc), .req_reg(req_reg), .req_ext(req_ext),
    .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data), .pc_we(pc_we),
    .pc_next(pc_next), .reg_we(reg_we), .reg_wdata(reg_wdata), .done(done)
  );

  // memory model: upper bits of every word are nonzero patterns
  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'hC35} ^ 16'h5A00;
  endfunction

  assign mem_rd_ready = mem_rd_valid && (stall_cnt == 0);
  assign mem_rd_data  = mem_word(mem_rd_addr);

  always @(posedge clk) begin
    if (!mem_rd_valid || mem_rd_ready) stall_cnt <= stall_cfg;
    else stall_cnt <= stall_cnt - 1;
    if (mem_rd_valid && mem_rd_ready) begin
      if (nlog < 4) flog[nlog] <= mem_rd_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected pointer, restated with signed integer arithmetic
  function automatic logic [19:0] exp_ptr(input logic [2:0] m, input logic w,
      input logic [19:0] pc, input logic [19:0] rg, input logic [19:0] ext);
    int off;
    off = w ? int'(ext) : int'($signed(ext[15:0]));
    case (m)
      3'd2:    return 20'((int'(pc) + off) & 32'hFFFFF);
      3'd6:    return 20'((int'(rg) + off) & 32'hFFFFF);
      3'd3:    return ext;
      default: return rg;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m, input logic w);
    if (w) return "R6";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd6: return "R5";
      3'd5: return "R8";
      default: return "R7";
    endcase
  endfunction

  typedef struct packed {
    logic [2:0]  mode;
    logic        wide;
    logic [19:0] pc;
    logic [19:0] rg;
    logic [19:0] ext;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 20'h12345, 20'h00000, 20'h1AA04, 2'd0},
    '{3'd1, 1'b0, 20'h00100, 20'hABCDE, 20'h00000, 2'd0},
    '{3'd2, 1'b0, 20'h04000, 20'h00000, 20'h00123, 2'd0},
    '{3'd2, 1'b0, 20'hFFFF0, 20'h00000, 20'h00020, 2'd1},
    '{3'd3, 1'b0, 20'h00000, 20'h00000, 20'hC0FFE, 2'd2},
    '{3'd4, 1'b0, 20'h00000, 20'h3A5A0, 20'h00000, 2'd0},
    '{3'd5, 1'b0, 20'h00000, 20'hFFFFE, 20'h00000, 2'd1},
    '{3'd6, 1'b0, 20'h00000, 20'h20000, 20'h0FFFE, 2'd0},
    '{3'd6, 1'b1, 20'h00000, 20'h20000, 20'h80004, 2'd0},
    '{3'd2, 1'b1, 20'h10000, 20'h00000, 20'hF8000, 2'd0},
    '{3'd5, 1'b0, 20'h00000, 20'h01000, 20'h00000, 2'd2}
  };

  task automatic issue(input logic [2:0] m, input logic w, input logic [19:0] pc,
      input logic [19:0] rg, input logic [19:0] ext);
    req_mode = m; req_wide = w; req_pc = pc; req_reg = rg; req_ext = ext;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int cyc;
    logic [19:0] p, exp_tgt, hi_a;
    logic fetch;
    string t;
    t = mode_tag(v.mode, v.wide);
    fetch = (v.mode >= 3'd2);
    p = exp_ptr(v.mode, v.wide, v.pc, v.rg, v.ext);
    hi_a = 20'((32'(p) + 2) & 32'hFFFFF);
    if (v.mode == 3'd0) exp_tgt = v.ext;
    else if (v.mode == 3'd1) exp_tgt = v.rg;
    else exp_tgt = {mem_word(hi_a)[3:0], mem_word(p)};
    stall_cfg = int'(v.stall);
    @(negedge clk);
    nlog = 0;
    issue(v.mode, v.wide, v.pc, v.rg, v.ext);
    wait_done(cyc);
    chk({t, " R10 done seen"}, 32'(done), 32'd1);
    chk({t, " R10 pc_we with done"}, 32'(pc_we), 32'd1);
    chk({t, fetch ? " R4 R13 target" : " target"}, 32'(pc_next), 32'(exp_tgt));
    chk({t, " R9 latency"}, 32'(cyc), fetch ? 32'(3 + 2 * int'(v.stall)) : 32'd1);
    chk({t, " R8 reg_we"}, 32'(reg_we), (v.mode == 3'd5) ? 32'd1 : 32'd0);
    if (v.mode == 3'd5)
      chk("R8 write-back value", 32'(reg_wdata), (32'(v.rg) + 4) & 32'hFFFFF);
    chk({t, " R4 read count"}, 32'(nlog), fetch ? 32'd2 : 32'd0);
    if (fetch) begin
      chk({t, " R4 low read address"}, 32'(flog[0]), 32'(p));
      chk({t, " R4 high read address"}, 32'(flog[1]), 32'(hi_a));
    end
    @(negedge clk);
    chk({t, " R10 pulse ends"}, 32'({done, pc_we, reg_we}), 32'd0);
  endtask

  initial begin
    int cyc;
    logic [19:0] exp_t;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs", 32'({busy, done, pc_we, reg_we, mem_rd_valid}), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: a request while busy is dropped
    stall_cfg = 3;
    @(negedge clk);
    nlog = 0;
    issue(3'd3, 1'b0, 20'h0, 20'h0, 20'h05000);
    @(negedge clk);
    chk("R11 busy during fetch", 32'(busy), 32'd1);
    issue(3'd0, 1'b0, 20'h0, 20'h0, 20'h11111);
    wait_done(cyc);
    exp_t = {mem_word(20'h05002)[3:0], mem_word(20'h05000)};
    chk("R11 target unaffected", 32'(pc_next), 32'(exp_t));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 no second branch", 32'({done, busy}), 32'd0);
    end

    // R12: mode code 7 ignored
    nlog = 0;
    issue(3'd7, 1'b0, 20'h0, 20'h12345, 20'h54321);
    for (int k = 0; k < 4; k++) begin
      chk("R12 ignored mode", 32'({busy, done, mem_rd_valid}), 32'd0);
      @(negedge clk);
    end
    chk("R12 no reads", 32'(nlog), 32'd0);

    // R1: reset in the middle of a fetch returns to idle
    stall_cfg = 3;
    issue(3'd4, 1'b0, 20'h0, 20'h00400, 20'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset aborts", 32'({busy, mem_rd_valid, done}), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule